// File: doc/BRIEF.md
# Power Mode Transition Controller

This block keeps track of which operating mode a small 8-bit microcontroller is in: one of two running modes (high-speed active or low-speed subactive) or one of four low-power modes (sleep, subsleep, standby, watch). The CPU programs an 8-bit control register over a simple byte bus. The CPU then raises a one-cycle sleep request, and the block picks the low-power mode to enter. It bases that choice on the running mode it is leaving, the register's standby-select bit and a watch-enable input, so one request can lead to four different low-power modes.

A one-cycle wake-up pulse ends a low-power mode. The block then returns to a running mode that depends on which low-power mode it was in. When leaving watch mode, the register's low-speed bit chooses between subactive and active. The current mode is reported as a one-hot vector and held until a valid request or wake-up changes it.

Top module: `pmc_power_mode_ctrl`

## Requirements
- R1: After a synchronous reset, the mode is active (`mode_onehot` = 6'b000001) and the control register reads 0x07.
- R2: A write with `bus_wr`=1 at address `REG_ADDR` updates the register at the clock edge. A read at `REG_ADDR` returns it through the combinational `bus_rdata`. The fields are: bit 7 standby select, bits 6:4 settling select, bit 3 low-speed select, bit 2 reserved, bits 1:0 divider select. Bit 2 always reads 1, whatever value is written.
- R3: A write to any other address leaves the register unchanged. A read at any other address returns 0x00.
- R4: A sleep request in active mode with standby select 0 enters sleep mode (bit 2) at the next edge.
- R5: A sleep request in subactive mode with standby select 0 enters subsleep mode (bit 3).
- R6: A sleep request in active mode with standby select 1 enters watch mode (bit 5) if `watch_en`=1, and standby mode (bit 4) if `watch_en`=0.
- R7: A sleep request in subactive mode with standby select 1 enters watch mode whatever the value of `watch_en`.
- R8: A wake-up returns sleep mode and standby mode to active mode (bit 0), and returns subsleep mode to subactive mode (bit 1).
- R9: A wake-up in watch mode goes to subactive mode if low-speed select is 1, and to active mode if it is 0.
- R10: A sleep request in a low-power mode is ignored, and a wake-up in a running mode is ignored. If both arrive together in a low-power mode, the wake-up takes effect.
- R11: `mode_onehot` always has exactly one bit set. With no request it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| sleep_req | input | 1 | One-cycle sleep request |
| wake_req | input | 1 | One-cycle wake-up |
| watch_en | input | 1 | Chooses watch over standby from active mode |
| mode_onehot | output | 6 | One-hot mode: 0 active, 1 subactive, 2 sleep, 3 subsleep, 4 standby, 5 watch |

## Verification
The bench builds the block with `REG_ADDR` = 0xA5 and `RD_REG` = 0, so the register does not sit at the default address. A write to a neighbouring address is therefore a real miss, and readback is available in the same cycle. Subactive mode can only be reached by waking from watch with the low-speed bit set, so the vector table walks that route before it exercises the subsleep path and the forced-watch path.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int NUM_MODES = 6;
   localparam int MODE_W    = 3;

   typedef enum logic [MODE_W-1:0] {
      MD_ACTIVE = 3'd0,
      MD_SUBACT = 3'd1,
      MD_SLEEP  = 3'd2,
      MD_SUBSLP = 3'd3,
      MD_STBY   = 3'd4,
      MD_WATCH  = 3'd5
   } mode_t;

   typedef struct packed {
      logic       stby_sel;
      logic [2:0] settle_sel;
      logic       lowspd_sel;
      logic       rsv_one;
      logic [1:0] div_sel;
   } ctl_t;

   function automatic logic is_running(mode_t m);
      return (m == MD_ACTIVE) || (m == MD_SUBACT);
   endfunction
endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
   import pmc_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter logic [7:0]  RESET_VAL = 8'h07,
   parameter int          RD_REG    = 0,
   parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output ctl_t              ctl_q
);
   localparam int RSV_BIT = 2;

   logic       hit;
   logic [7:0] rd_mux;
   logic [7:0] wr_val;

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_aw
         $error("pmc_ctrl_reg: ADDR_W out of range");
      end
      if (RESET_VAL[RSV_BIT] != 1'b1) begin : g_bad_rv
         $error("pmc_ctrl_reg: reserved bit must reset to one");
      end
   endgenerate

   assign hit = (bus_addr == REG_ADDR);

   always_comb begin
      wr_val          = bus_wdata;
      wr_val[RSV_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)
         ctl_q <= ctl_t'(RESET_VAL);
      else if (bus_wr && hit)
         ctl_q <= ctl_t'(wr_val);
   end

   assign rd_mux = hit ? 8'(ctl_q) : 8'h00;

   generate
      if (RD_REG != 0) begin : g_rd_reg
         logic [7:0] rd_q;
         always_ff @(posedge clk) begin
            if (rst) rd_q <= 8'h00;
            else     rd_q <= rd_mux;
         end
         assign bus_rdata = rd_q;
      end else begin : g_rd_comb
         assign bus_rdata = rd_mux;
      end
   endgenerate

   assert_rsv_one_R2: assert property (@(posedge clk) disable iff (rst)
      ctl_q.rsv_one == 1'b1);

   assert_miss_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !(bus_wr && hit) |=> $stable(ctl_q));
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
   import pmc_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  sleep_req,
   input  logic  wake_req,
   input  logic  watch_en,
   input  logic  stby_sel,
   input  logic  lowspd_sel,
   output mode_t mode_q
);
   mode_t mode_d;

   always_comb begin
      mode_d = mode_q;
      if (is_running(mode_q)) begin
         if (sleep_req) begin
            if (!stby_sel)
               mode_d = (mode_q == MD_ACTIVE) ? MD_SLEEP : MD_SUBSLP;
            else if (mode_q == MD_SUBACT || watch_en)
               mode_d = MD_WATCH;
            else
               mode_d = MD_STBY;
         end
      end else if (wake_req) begin
         unique case (mode_q)
            MD_SUBSLP: mode_d = MD_SUBACT;
            MD_WATCH:  mode_d = lowspd_sel ? MD_SUBACT : MD_ACTIVE;
            default:   mode_d = MD_ACTIVE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) mode_q <= MD_ACTIVE;
      else     mode_q <= mode_d;
   end

   assert_act_sleep_R4: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MD_ACTIVE && sleep_req && !stby_sel) |=> (mode_q == MD_SLEEP));

   assert_sub_sleep_R5: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MD_SUBACT && sleep_req && !stby_sel) |=> (mode_q == MD_SUBSLP));

   assert_sub_watch_R7: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MD_SUBACT && sleep_req && stby_sel) |=> (mode_q == MD_WATCH));

   assert_lp_ignore_sleep_R10: assert property (@(posedge clk) disable iff (rst)
      (!is_running(mode_q) && !wake_req) |=> $stable(mode_q));

   assert_run_ignore_wake_R10: assert property (@(posedge clk) disable iff (rst)
      (is_running(mode_q) && !sleep_req) |=> $stable(mode_q));
endmodule

// File: rtl/pmc_mode_decode.sv
module pmc_mode_decode
   import pmc_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst,
   input  mode_t                mode,
   output logic [NUM_MODES-1:0] onehot
);
   generate
      for (genvar i = 0; i < NUM_MODES; i++) begin : g_bit
         assign onehot[i] = (mode == mode_t'(i));
      end
   endgenerate

   assert_onehot_R11: assert property (@(posedge clk) disable iff (rst)
      $onehot(onehot));
endmodule

// File: rtl/pmc_power_mode_ctrl.sv
module pmc_power_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR  = 8'hF0,
   parameter logic [7:0]        RESET_VAL = 8'h07,
   parameter int                RD_REG    = 0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [7:0]           bus_wdata,
   output logic [7:0]           bus_rdata,
   input  logic                 sleep_req,
   input  logic                 wake_req,
   input  logic                 watch_en,
   output logic [NUM_MODES-1:0] mode_onehot
);
   ctl_t  ctl;
   mode_t mode;

   generate
      if (RD_REG != 0 && RD_REG != 1) begin : g_bad_rd
         $error("pmc_power_mode_ctrl: RD_REG must be 0 or 1");
      end
   endgenerate

   pmc_ctrl_reg #(
      .ADDR_W(ADDR_W), .RESET_VAL(RESET_VAL), .RD_REG(RD_REG), .REG_ADDR(REG_ADDR)
   ) u_reg (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_q(ctl)
   );

   pmc_mode_fsm u_fsm (
      .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
      .watch_en(watch_en), .stby_sel(ctl.stby_sel), .lowspd_sel(ctl.lowspd_sel),
      .mode_q(mode)
   );

   pmc_mode_decode u_dec (
      .clk(clk), .rst(rst), .mode(mode), .onehot(mode_onehot)
   );

   assert_wake_sleep_R8: assert property (@(posedge clk) disable iff (rst)
      ((mode_onehot[2] || mode_onehot[4]) && wake_req) |=> mode_onehot[0]);

   assert_watch_wake_R9: assert property (@(posedge clk) disable iff (rst)
      (mode_onehot[5] && wake_req && ctl.lowspd_sel) |=> mode_onehot[1]);
endmodule

// File: tb/sim_pmc_power_mode_ctrl.sv
module sim_pmc_power_mode_ctrl;
   localparam logic [7:0] ADDR = 8'hA5;
   localparam int NV = 20;
   localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_SLP = 2'd2, OP_WAK = 2'd3;

   logic       clk = 0, rst = 1;
   logic [7:0] bus_addr = ADDR, bus_wdata = 0, bus_rdata;
   logic       bus_wr = 0, sleep_req = 0, wake_req = 0, watch_en = 0;
   logic [5:0] mode_onehot;
   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   pmc_power_mode_ctrl #(.ADDR_W(8), .REG_ADDR(ADDR), .RD_REG(0)) u0 (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_req(sleep_req),
      .wake_req(wake_req), .watch_en(watch_en), .mode_onehot(mode_onehot));

   // {op, addr, wdata, watch_en, exp_mode, exp_rd}
   localparam logic [29:0] TBL [NV] = '{
      {OP_WR,  ADDR,  8'h00, 1'b0, 3'd0, 8'h04},  // R2 bit2 forced
      {OP_SLP, ADDR,  8'h00, 1'b0, 3'd2, 8'h04},  // R4
      {OP_SLP, ADDR,  8'h00, 1'b0, 3'd2, 8'h04},  // R10
      {OP_WAK, ADDR,  8'h00, 1'b0, 3'd0, 8'h04},  // R8
      {OP_WR,  ADDR,  8'h80, 1'b0, 3'd0, 8'h84},  // R2
      {OP_SLP, ADDR,  8'h00, 1'b0, 3'd4, 8'h84},  // R6 standby
      {OP_WAK, ADDR,  8'h00, 1'b0, 3'd0, 8'h84},  // R8
      {OP_SLP, ADDR,  8'h00, 1'b1, 3'd5, 8'h84},  // R6 watch
      {OP_WAK, ADDR,  8'h00, 1'b0, 3'd0, 8'h84},  // R9 lowspd 0
      {OP_WR,  ADDR,  8'h88, 1'b0, 3'd0, 8'h8C},  // R2
      {OP_SLP, ADDR,  8'h00, 1'b1, 3'd5, 8'h8C},  // R6
      {OP_WAK, ADDR,  8'h00, 1'b0, 3'd1, 8'h8C},  // R9 lowspd 1
      {OP_WAK, ADDR,  8'h00, 1'b0, 3'd1, 8'h8C},  // R10
      {OP_SLP, ADDR,  8'h00, 1'b0, 3'd5, 8'h8C},  // R7
      {OP_WAK, ADDR,  8'h00, 1'b0, 3'd1, 8'h8C},  // R9
      {OP_WR,  ADDR,  8'h08, 1'b0, 3'd1, 8'h0C},  // R2
      {OP_SLP, ADDR,  8'h00, 1'b0, 3'd3, 8'h0C},  // R5
      {OP_WR,  8'h3C, 8'hFF, 1'b0, 3'd3, 8'h0C},  // R3
      {OP_WAK, ADDR,  8'h00, 1'b0, 3'd1, 8'h0C},  // R8 subsleep
      {OP_WR,  ADDR,  8'h7B, 1'b0, 3'd1, 8'h7F}   // R2
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      bus_wr = 0; sleep_req = 0; wake_req = 0; bus_addr = ADDR;
      #0;
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst = 0;
      @(negedge clk);
      chk("R1 mode", {2'b0, mode_onehot}, 8'h01);
      chk("R1 reg", bus_rdata, 8'h07);
      bus_addr = 8'hA4; #1;
      chk("R3 read miss", bus_rdata, 8'h00);
      bus_addr = ADDR;

      for (int i = 0; i < NV; i++) begin
         logic [1:0] op;
         op = TBL[i][29:28];
         bus_addr = TBL[i][27:20]; bus_wdata = TBL[i][19:12]; watch_en = TBL[i][11];
         bus_wr = (op == OP_WR); sleep_req = (op == OP_SLP); wake_req = (op == OP_WAK);
         step(); #1;
         chk($sformatf("R4-R9 vec%0d mode", i), {2'b0, mode_onehot}, 8'(6'd1 << TBL[i][10:8]));
         chk($sformatf("R2 vec%0d reg", i), bus_rdata, TBL[i][7:0]);
         chk("R11 onehot", 8'($countones(mode_onehot)), 8'd1);
      end

      // R11 hold with no requests
      repeat (5) step();
      #1; chk("R11 hold", {2'b0, mode_onehot}, 8'h02);

      // R10 simultaneous sleep and wake in subsleep: wake wins
      bus_wr = 1; bus_wdata = 8'h00; step();
      sleep_req = 1; step();
      #1; chk("R5 subsleep", {2'b0, mode_onehot}, 8'h08);
      sleep_req = 1; wake_req = 1; step();
      #1; chk("R10 both", {2'b0, mode_onehot}, 8'h02);

      // R1 reset in low-power mode
      sleep_req = 1; step();
      rst = 1; step(); rst = 0; #1;
      chk("R1 reset mode", {2'b0, mode_onehot}, 8'h01);
      chk("R1 reset reg", bus_rdata, 8'h07);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule